// File: doc/BRIEF.md
# Array Interrupt Merger with Single-Line Masking

This block takes four level-sensitive interrupt requests raised by a compute array, folds a set of internal error flags into each of them, and drives four registered interrupt outputs toward the system interrupt controller. At system level the outputs carry the numbers 4 to 7. Inside the block the line with index 0 stands for interrupt 4, and indices 1 to 3 stand for interrupts 5 to 7.

Software controls masking through three 32-bit registers on a small memory-mapped slave port. The port has AXI4-Lite style channels, with separate address, write-data, write-response, read-address and read-data handshakes. The mask status register can only be read. The enable register and the disable register can only be written, and each bit they receive acts as a set or clear command on the mask. Only line 0 has a mask bit. Lines 1 to 3 have no mask storage, so nothing software writes can silence them.

Top module: `irq_merge_top`

## Requirements
- R1: After reset every bit of `irq_o` is 0, and the mask status register (offset 0x0) reads 0x0000_0001, meaning line 0 is masked.
- R2: For index i in 1..3, `irq_o[i]` equals `arr_irq_i[i]` OR any bit of `err_src_i`, one clock later, whatever has been written to the registers.
- R3: Each bit of `err_src_i` is ORed into all four lines before masking, so a single error flag raises every unmasked output.
- R4: `irq_o[0]` equals (`arr_irq_i[0]` OR any error) AND NOT mask bit 0, registered with one cycle of latency.
- R5: A write to the enable register (offset 0x4) with bit 0 set clears mask bit 0. A write with bit 0 clear leaves the mask unchanged.
- R6: A write to the disable register (offset 0x8) with bit 0 set sets mask bit 0. A write with bit 0 clear leaves the mask unchanged.
- R7: Bits 31..1 of enable and disable writes are discarded. Bits 31..1 of the mask status register always read 0.
- R8: A write to the mask status register (offset 0x0) has no effect on the mask.
- R9: Reads of the enable register, the disable register and the unused offset 0xC return 0. Every read and write response is OKAY (2'b00).
- R10: A write is accepted only on a cycle where both the address and data valids are high. `s_bvalid` stays high until `s_bready`, and no new write is accepted meanwhile. `s_rvalid` and `s_rdata` stay steady until `s_rready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| arr_irq_i | input | 4 | Interrupt requests from the array; index 0 is interrupt 4 |
| err_src_i | input | 2 | Internal error flags, ORed into every line |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | 4 | Write byte address |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | 32 | Write data |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | 4 | Read byte address |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| irq_o | output | 4 | Registered interrupt outputs 4..7 |

## Verification
The hardest case to reach from the ports is a register write that must change nothing. Examples are a zero bit sent to the enable or disable register, a write to the read-only status register, and a write that sets only the discarded high bits. None of these is visible unless the line 0 mask is first placed in the opposite state. The stimulus therefore first steers the mask through a real enable or disable write. It then issues the no-effect write and confirms both the status readback and `irq_o[0]` while `arr_irq_i[0]` is held high. A second hard case is a back-pressured write response. For that case the bench holds `s_bready` low for several cycles and confirms that a waiting write is not taken.

// File: rtl/irq_merge_pkg.sv
package irq_merge_pkg;

  typedef enum logic [1:0] {
    SEL_MASK_STAT = 2'd0,
    SEL_UNMASK    = 2'd1,
    SEL_MASK_SET  = 2'd2,
    SEL_NONE      = 2'd3
  } reg_sel_e;

  localparam logic [1:0] RESP_OKAY = 2'b00;

  localparam int unsigned WORD_SHIFT = 2;

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/irq_bus_slave.sv
module irq_bus_slave #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              awvalid,
  output logic              awready,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              wvalid,
  output logic              wready,
  input  logic [DATA_W-1:0] wdata,
  output logic              bvalid,
  input  logic              bready,
  output logic [1:0]        bresp,
  input  logic              arvalid,
  output logic              arready,
  input  logic [ADDR_W-1:0] araddr,
  output logic              rvalid,
  input  logic              rready,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        rresp,
  output logic              wr_fire,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data
);

  import irq_merge_pkg::*;

  logic              bvalid_q, bvalid_d;
  logic              rvalid_q, rvalid_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rdata_en;
  logic              rd_fire;

  // both write channels must be present; the response slot must be free
  assign awready = !bvalid_q && wvalid;
  assign wready  = !bvalid_q && awvalid;
  assign wr_fire = awvalid && wvalid && !bvalid_q;
  assign wr_addr = awaddr;
  assign wr_data = wdata;

  assign arready = !rvalid_q;
  assign rd_fire = arvalid && !rvalid_q;
  assign rd_addr = araddr;

  always_comb begin
    bvalid_d = bvalid_q;
    if (wr_fire) begin
      bvalid_d = 1'b1;
    end else if (bready) begin
      bvalid_d = 1'b0;
    end
  end

  always_comb begin
    rvalid_d = rvalid_q;
    rdata_en = 1'b0;
    rdata_d  = rdata_q;
    if (rd_fire) begin
      rvalid_d = 1'b1;
      rdata_en = 1'b1;
      rdata_d  = rd_data;
    end else if (rready) begin
      rvalid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bvalid_q <= 1'b0;
      rvalid_q <= 1'b0;
    end else begin
      bvalid_q <= bvalid_d;
      rvalid_q <= rvalid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rdata_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign bvalid = bvalid_q;
  assign bresp  = RESP_OKAY;
  assign rvalid = rvalid_q;
  assign rdata  = rdata_q;
  assign rresp  = RESP_OKAY;

endmodule

// File: rtl/irq_mask_regs.sv
module irq_mask_regs #(
  parameter int unsigned NUM_LINES = 4,
  parameter int unsigned MASKABLE  = 1,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_fire,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [DATA_W-1:0]    rd_data,
  output logic [NUM_LINES-1:0] mask_o
);

  import irq_merge_pkg::*;

  localparam int unsigned WORD_W = ADDR_W - WORD_SHIFT;

  reg_sel_e wr_sel;
  reg_sel_e rd_sel;
  logic     unmask_hit;
  logic     mask_hit;

  function automatic reg_sel_e decode(input logic [ADDR_W-1:0] addr);
    logic [WORD_W-1:0] word;
    word = addr[ADDR_W-1:WORD_SHIFT];
    if (word == WORD_W'(0))      decode = SEL_MASK_STAT;
    else if (word == WORD_W'(1)) decode = SEL_UNMASK;
    else if (word == WORD_W'(2)) decode = SEL_MASK_SET;
    else                         decode = SEL_NONE;
  endfunction

  assign wr_sel     = decode(wr_addr);
  assign rd_sel     = decode(rd_addr);
  assign unmask_hit = wr_fire && (wr_sel == SEL_UNMASK);
  assign mask_hit   = wr_fire && (wr_sel == SEL_MASK_SET);

  genvar gi;
  generate
    for (gi = 0; gi < NUM_LINES; gi++) begin : g_line
      if (gi < MASKABLE) begin : g_stored
        logic bit_q, bit_d, bit_en;
        always_comb begin
          bit_en = 1'b0;
          bit_d  = bit_q;
          // disable side takes priority over enable side
          if (mask_hit && wr_data[gi]) begin
            bit_en = 1'b1;
            bit_d  = 1'b1;
          end else if (unmask_hit && wr_data[gi]) begin
            bit_en = 1'b1;
            bit_d  = 1'b0;
          end
        end
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            bit_q <= 1'b1;
          end else if (bit_en) begin
            bit_q <= bit_d;
          end
        end
        assign mask_o[gi] = bit_q;
      end else begin : g_fixed
        assign mask_o[gi] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    if (rd_sel == SEL_MASK_STAT) begin
      rd_data = DATA_W'(mask_o);
    end
  end

  logic unused_bits;
  assign unused_bits = ^{wr_data[DATA_W-1:MASKABLE], wr_addr[WORD_SHIFT-1:0], rd_addr[WORD_SHIFT-1:0]};

endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
  parameter int unsigned NUM_LINES = 4,
  parameter int unsigned NUM_ERR   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] arr_irq,
  input  logic [NUM_ERR-1:0]   err_src,
  input  logic [NUM_LINES-1:0] mask,
  output logic [NUM_LINES-1:0] irq
);

  logic                 any_err;
  logic [NUM_LINES-1:0] merged;
  logic [NUM_LINES-1:0] irq_d;
  logic [NUM_LINES-1:0] irq_q;

  assign any_err = |err_src;

  genvar gl;
  generate
    for (gl = 0; gl < NUM_LINES; gl++) begin : g_merge
      always_comb begin
        merged[gl] = arr_irq[gl] | any_err;
        irq_d[gl]  = merged[gl] & ~mask[gl];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= '0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq = irq_q;

endmodule

// File: rtl/irq_merge_top.sv
module irq_merge_top #(
  parameter int unsigned NUM_LINES = 4,
  parameter int unsigned NUM_ERR   = 2,
  parameter int unsigned MASKABLE  = 1,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned SYNC_LEN  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] arr_irq_i,
  input  logic [NUM_ERR-1:0]   err_src_i,
  input  logic                 s_awvalid,
  output logic                 s_awready,
  input  logic [ADDR_W-1:0]    s_awaddr,
  input  logic                 s_wvalid,
  output logic                 s_wready,
  input  logic [DATA_W-1:0]    s_wdata,
  output logic                 s_bvalid,
  input  logic                 s_bready,
  output logic [1:0]           s_bresp,
  input  logic                 s_arvalid,
  output logic                 s_arready,
  input  logic [ADDR_W-1:0]    s_araddr,
  output logic                 s_rvalid,
  input  logic                 s_rready,
  output logic [DATA_W-1:0]    s_rdata,
  output logic [1:0]           s_rresp,
  output logic [NUM_LINES-1:0] irq_o
);

  logic                 rst_sync_n;
  logic                 wr_fire;
  logic [ADDR_W-1:0]    wr_addr;
  logic [DATA_W-1:0]    wr_data;
  logic [ADDR_W-1:0]    rd_addr;
  logic [DATA_W-1:0]    rd_data;
  logic [NUM_LINES-1:0] mask_vec;

  irq_rst_sync #(.STAGES(SYNC_LEN)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irq_bus_slave #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .awvalid (s_awvalid),
    .awready (s_awready),
    .awaddr  (s_awaddr),
    .wvalid  (s_wvalid),
    .wready  (s_wready),
    .wdata   (s_wdata),
    .bvalid  (s_bvalid),
    .bready  (s_bready),
    .bresp   (s_bresp),
    .arvalid (s_arvalid),
    .arready (s_arready),
    .araddr  (s_araddr),
    .rvalid  (s_rvalid),
    .rready  (s_rready),
    .rdata   (s_rdata),
    .rresp   (s_rresp),
    .wr_fire (wr_fire),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  irq_mask_regs #(
    .NUM_LINES (NUM_LINES),
    .MASKABLE  (MASKABLE),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_fire (wr_fire),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .mask_o  (mask_vec)
  );

  irq_out_stage #(.NUM_LINES(NUM_LINES), .NUM_ERR(NUM_ERR)) u_out (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .arr_irq (arr_irq_i),
    .err_src (err_src_i),
    .mask    (mask_vec),
    .irq     (irq_o)
  );

endmodule

// File: rtl/irq_merge_chk.sv
module irq_merge_chk #(
  parameter int unsigned NUM_LINES = 4,
  parameter int unsigned NUM_ERR   = 2,
  parameter int unsigned MASKABLE  = 1,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 32
) (
  input logic                 clk,
  input logic                 rst_ok,
  input logic [NUM_LINES-1:0] arr_irq_i,
  input logic [NUM_ERR-1:0]   err_src_i,
  input logic [NUM_LINES-1:0] irq_o,
  input logic [NUM_LINES-1:0] mask_vec,
  input logic                 s_awvalid,
  input logic                 s_awready,
  input logic [ADDR_W-1:0]    s_awaddr,
  input logic                 s_wvalid,
  input logic                 s_wready,
  input logic [DATA_W-1:0]    s_wdata,
  input logic                 s_bvalid,
  input logic                 s_bready,
  input logic [1:0]           s_bresp,
  input logic                 s_rvalid,
  input logic                 s_rready,
  input logic [DATA_W-1:0]    s_rdata,
  input logic [1:0]           s_rresp
);

  logic wr_hs;
  logic en_cmd;
  logic dis_cmd;
  assign wr_hs   = s_awvalid && s_awready && s_wvalid && s_wready;
  assign en_cmd  = wr_hs && (s_awaddr[ADDR_W-1:2] == 2'd1) && s_wdata[0];
  assign dis_cmd = wr_hs && (s_awaddr[ADDR_W-1:2] == 2'd2) && s_wdata[0];

  genvar gc;
  generate
    for (gc = MASKABLE; gc < NUM_LINES; gc++) begin : g_free
      AST_FREE_LINE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_ok)
        rst_ok |=> (irq_o[gc] == ($past(arr_irq_i[gc]) | (|$past(err_src_i))))); // R2
    end
  endgenerate

  AST_LINE0_GATED: assert property (@(posedge clk) disable iff (!rst_ok)
    mask_vec[0] |=> !irq_o[0]); // R4

  AST_LINE0_PASSES: assert property (@(posedge clk) disable iff (!rst_ok)
    (!mask_vec[0] && (arr_irq_i[0] || (|err_src_i))) |=> irq_o[0]); // R3

  AST_DISABLE_SETS: assert property (@(posedge clk) disable iff (!rst_ok)
    dis_cmd |=> mask_vec[0]); // R6

  AST_ENABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_ok)
    (en_cmd && !dis_cmd) |=> !mask_vec[0]); // R5

  AST_MASK_STEADY: assert property (@(posedge clk) disable iff (!rst_ok)
    (rst_ok && !en_cmd && !dis_cmd) |=> $stable(mask_vec)); // R8

  AST_RESP_OKAY: assert property (@(posedge clk) disable iff (!rst_ok)
    (s_bvalid || s_rvalid) |-> (s_bresp == 2'b00 && s_rresp == 2'b00)); // R9

  AST_BRESP_HOLD: assert property (@(posedge clk) disable iff (!rst_ok)
    (s_bvalid && !s_bready) |=> (s_bvalid && !s_awready)); // R10

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_ok)
    (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata))); // R10

endmodule

bind irq_merge_top irq_merge_chk #(
  .NUM_LINES (NUM_LINES),
  .NUM_ERR   (NUM_ERR),
  .MASKABLE  (MASKABLE),
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W)
) u_chk (
  .clk       (clk),
  .rst_ok    (rst_sync_n),
  .arr_irq_i (arr_irq_i),
  .err_src_i (err_src_i),
  .irq_o     (irq_o),
  .mask_vec  (mask_vec),
  .s_awvalid (s_awvalid),
  .s_awready (s_awready),
  .s_awaddr  (s_awaddr),
  .s_wvalid  (s_wvalid),
  .s_wready  (s_wready),
  .s_wdata   (s_wdata),
  .s_bvalid  (s_bvalid),
  .s_bready  (s_bready),
  .s_bresp   (s_bresp),
  .s_rvalid  (s_rvalid),
  .s_rready  (s_rready),
  .s_rdata   (s_rdata),
  .s_rresp   (s_rresp)
);

// File: tb/irq_merge_top_tb.sv
module irq_merge_top_tb;

  logic        clk;
  logic        rst_n;
  logic [3:0]  arr_irq_i;
  logic [1:0]  err_src_i;
  logic        s_awvalid, s_awready;
  logic [3:0]  s_awaddr;
  logic        s_wvalid, s_wready;
  logic [31:0] s_wdata;
  logic        s_bvalid, s_bready;
  logic [1:0]  s_bresp;
  logic        s_arvalid, s_arready;
  logic [3:0]  s_araddr;
  logic        s_rvalid, s_rready;
  logic [31:0] s_rdata;
  logic [1:0]  s_rresp;
  logic [3:0]  irq_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  localparam logic [3:0] A_STAT = 4'h0;
  localparam logic [3:0] A_EN   = 4'h4;
  localparam logic [3:0] A_DIS  = 4'h8;
  localparam logic [3:0] A_GAP  = 4'hC;

  irq_merge_top u_dut (
    .clk(clk), .rst_n(rst_n), .arr_irq_i(arr_irq_i), .err_src_i(err_src_i),
    .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr),
    .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata),
    .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
    .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr),
    .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata),
    .s_rresp(s_rresp), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] addr, input logic [31:0] data);
    @(negedge clk);
    s_awvalid = 1'b1; s_awaddr = addr; s_wvalid = 1'b1; s_wdata = data;
    @(negedge clk);
    s_awvalid = 1'b0; s_wvalid = 1'b0;
    chk(s_bvalid === 1'b1, "R10 bvalid after write", 32'(s_bvalid), 32'd1);
    chk(s_bresp === 2'b00, "R9 bresp", 32'(s_bresp), 32'd0);
    s_bready = 1'b1;
    @(negedge clk);
    s_bready = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] addr, output logic [31:0] data);
    @(negedge clk);
    s_arvalid = 1'b1; s_araddr = addr;
    @(negedge clk);
    s_arvalid = 1'b0;
    data = s_rdata;
    chk(s_rvalid === 1'b1, "R10 rvalid after read", 32'(s_rvalid), 32'd1);
    chk(s_rresp === 2'b00, "R9 rresp", 32'(s_rresp), 32'd0);
    s_rready = 1'b1;
    @(negedge clk);
    s_rready = 1'b0;
  endtask

  task automatic set_inputs(input logic [3:0] a, input logic [1:0] e);
    @(negedge clk);
    arr_irq_i = a; err_src_i = e;
  endtask

  task automatic expect_irq(input logic [3:0] exp, input string req);
    @(negedge clk);
    chk(irq_o === exp, req, 32'(irq_o), 32'(exp));
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk(irq_o === 4'b0000, "R1 irq after reset", 32'(irq_o), 32'd0);
    bus_read(A_STAT, d);
    chk(d === 32'h1, "R1 status after reset", d, 32'h1);
  endtask

  task automatic t_free_lines();
    set_inputs(4'b1110, 2'b00);
    chk(irq_o === 4'b0000, "R2 one-cycle latency", 32'(irq_o), 32'd0);
    expect_irq(4'b1110, "R2 free lines follow");
    set_inputs(4'b1111, 2'b00);
    expect_irq(4'b1110, "R4 line0 masked");
    set_inputs(4'b0100, 2'b00);
    expect_irq(4'b0100, "R2 single line");
  endtask

  task automatic t_errors();
    set_inputs(4'b0000, 2'b01);
    expect_irq(4'b1110, "R3 err0 fans out, line0 masked");
    set_inputs(4'b0000, 2'b10);
    expect_irq(4'b1110, "R3 err1 fans out");
    set_inputs(4'b0000, 2'b00);
    expect_irq(4'b0000, "R3 errors cleared");
  endtask

  task automatic t_enable_disable();
    logic [31:0] d;
    bus_write(A_EN, 32'h0000_0000);
    bus_read(A_STAT, d);
    chk(d === 32'h1, "R5 zero enable ignored", d, 32'h1);
    bus_write(A_EN, 32'h0000_0001);
    bus_read(A_STAT, d);
    chk(d === 32'h0, "R5 enable clears mask", d, 32'h0);
    set_inputs(4'b0001, 2'b00);
    expect_irq(4'b0001, "R4 line0 passes when unmasked");
    set_inputs(4'b0000, 2'b10);
    expect_irq(4'b1111, "R3 error reaches unmasked line0");
    set_inputs(4'b0001, 2'b00);
    bus_write(A_DIS, 32'h0000_0000);
    expect_irq(4'b0001, "R6 zero disable ignored");
    bus_write(A_DIS, 32'h0000_0001);
    expect_irq(4'b0000, "R6 disable gates line0");
    bus_read(A_STAT, d);
    chk(d === 32'h1, "R6 disable sets mask", d, 32'h1);
  endtask

  task automatic t_imr_write();
    logic [31:0] d;
    bus_write(A_STAT, 32'h0000_0000);
    bus_read(A_STAT, d);
    chk(d === 32'h1, "R8 status write ignored (masked)", d, 32'h1);
    expect_irq(4'b0000, "R8 line0 still gated");
    bus_write(A_EN, 32'h0000_0001);
    bus_write(A_STAT, 32'hFFFF_FFFF);
    bus_read(A_STAT, d);
    chk(d === 32'h0, "R8 status write ignored (unmasked)", d, 32'h0);
  endtask

  task automatic t_discard();
    logic [31:0] d;
    set_inputs(4'b1111, 2'b00);
    bus_write(A_DIS, 32'hFFFF_FFFE);
    expect_irq(4'b1111, "R7 high disable bits discarded");
    bus_read(A_STAT, d);
    chk(d === 32'h0, "R7 status after high-bit disable", d, 32'h0);
    bus_write(A_DIS, 32'hFFFF_FFFF);
    bus_read(A_STAT, d);
    chk(d === 32'h1, "R7 status upper bits zero", d, 32'h1);
    expect_irq(4'b1110, "R2 free lines unaffected by full disable");
    bus_write(A_EN, 32'hFFFF_FFFE);
    bus_read(A_STAT, d);
    chk(d === 32'h1, "R7 high enable bits discarded", d, 32'h1);
    set_inputs(4'b0000, 2'b00);
  endtask

  task automatic t_wo_reads();
    logic [31:0] d;
    bus_read(A_EN, d);
    chk(d === 32'h0, "R9 enable reg reads zero", d, 32'h0);
    bus_read(A_DIS, d);
    chk(d === 32'h0, "R9 disable reg reads zero", d, 32'h0);
    bus_read(A_GAP, d);
    chk(d === 32'h0, "R9 unused offset reads zero", d, 32'h0);
  endtask

  task automatic t_handshake();
    logic [31:0] d;
    // address without data: must not be taken
    @(negedge clk);
    s_awvalid = 1'b1; s_awaddr = A_EN; s_wdata = 32'h1;
    @(negedge clk);
    chk(s_bvalid === 1'b0, "R10 address alone not accepted", 32'(s_bvalid), 32'd0);
    s_awvalid = 1'b0;
    bus_read(A_STAT, d);
    chk(d === 32'h1, "R10 mask kept after lone address", d, 32'h1);
    // response back-pressure
    @(negedge clk);
    s_awvalid = 1'b1; s_wvalid = 1'b1; s_awaddr = A_EN; s_wdata = 32'h1;
    @(negedge clk);
    s_awaddr = A_DIS;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(s_bvalid === 1'b1 && s_awready === 1'b0, "R10 bvalid held, no accept",
          {30'd0, s_bvalid, s_awready}, 32'd2);
    end
    s_awvalid = 1'b0; s_wvalid = 1'b0;
    s_bready = 1'b1;
    @(negedge clk);
    s_bready = 1'b0;
    bus_read(A_STAT, d);
    chk(d === 32'h0, "R10 pending write not taken", d, 32'h0);
    // read back-pressure
    @(negedge clk);
    s_arvalid = 1'b1; s_araddr = A_STAT;
    @(negedge clk);
    s_arvalid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(s_rvalid === 1'b1 && s_rdata === 32'h0 && s_arready === 1'b0,
          "R10 rvalid and rdata held", s_rdata, 32'h0);
    end
    s_rready = 1'b1;
    @(negedge clk);
    s_rready = 1'b0;
    chk(s_rvalid === 1'b0, "R10 rvalid drops after rready", 32'(s_rvalid), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0;
    arr_irq_i = '0; err_src_i = '0;
    s_awvalid = 1'b0; s_awaddr = '0; s_wvalid = 1'b0; s_wdata = '0; s_bready = 1'b0;
    s_arvalid = 1'b0; s_araddr = '0; s_rready = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_free_lines();
    t_errors();
    t_enable_disable();
    t_imr_write();
    t_discard();
    t_wo_reads();
    t_handshake();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule